// File: doc/BRIEF.md
# Gated Two-Level Input Router

This block feeds the eight inputs of one group of timer cells. It takes 40 candidate signals, arranged as five source groups of eight lines each. Groups 0 and 1 are I/O lines, groups 2 and 3 are timer-cell lines, and group 4 carries filter and interrupt lines. It drives eight routed output lines.

Each output line has its own configuration byte, which holds three fields:
- a line-select code that picks the same line position inside every source group at once;
- a group-select code that picks one of those five candidates;
- a per-line enable.

An output passes its selected signal only when its enable is set, the global array enable is set and its group-select code is valid. In every other case the output is held low.

The routing path is purely combinational. Configuration lives in three registers on a simple write-strobe / combinational-read register bus.

Top module: `grp_input_router`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and every routed output is low, whatever the source inputs are.
- R2: Output line k is configured by byte k%4 of the register at offset 0x0 (lines 0-3) or 0x4 (lines 4-7). Inside the byte, bits [2:0] hold the line-select code, bits [5:3] hold the group-select code, bit 6 is the line enable, and bit 7 always reads zero.
- R3: Bit 0 of offset 0x8 is the global array enable. All other bits of that register read zero.
- R4: Take an output whose line enable and global enable are set and whose group-select code g is 0 to 4, with line-select code s. That output equals src_in[g*8+s]. Source bit g*8+i is line i of group g, where groups 0 and 1 are I/O, groups 2 and 3 are timer cells, and group 4 is filter/interrupt.
- R5: Group-select codes 5, 6 and 7 are reserved. Any line configured with one of them is held low.
- R6: A line whose enable bit is clear is held low.
- R7: While the global enable is clear, all outputs are low.
- R8: A register write takes effect on the first rising clock edge at which the write strobe is sampled high, and not before. Changes on the source inputs reach the outputs with no clock edge. Without a write strobe, the configuration does not change.
- R9: Writes to offsets other than 0x0, 0x4 and 0x8 change no register and no output. Reads from those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset, shared by reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| src_in | input | 40 | Five source groups of eight lines, group g at bits [8g+7:8g] |
| route_out | output | 8 | Routed and gated output lines |

## Verification
The bench sweeps every pairing of line-select and group-select code on every line. It uses one-hot and inverted source patterns, so a router that selected the line per group, ignored the line code or mapped a group code to the wrong group would raise or drop the wrong bit. Reserved group codes are driven with all sources high, which exposes a design that wraps or aliases them onto a real group instead of forcing the output low. The per-line enable and the global enable are each cleared alone under all-high sources, catching a gate that was missed. A write is checked both before and after its clock edge, together with ignored writes to undefined offsets, to catch registers that load early, mask reserved bits wrongly or decode addresses loosely.

// File: rtl/grp_router_pkg.sv
// Package: default dimensions and derived helpers shared by the router modules.
// Assumes each configuration byte holds two select codes, an enable and a spare bit.
package grp_router_pkg;

    localparam int DEF_N_GRP  = 5;   // number of source groups
    localparam int DEF_SRC_W  = 8;   // lines per source group
    localparam int DEF_N_OUT  = 8;   // routed output lines
    localparam int DEF_SEL_W  = 3;   // width of each select code
    localparam int DEF_ADDR_W = 4;   // register offset width
    localparam int DEF_REG_W  = 32;  // register width

    // Bits used by one line's configuration: two select codes, an enable and a spare bit.
    function automatic int line_bits(input int sel_w);
        return 2 * sel_w + 2;
    endfunction

endpackage

// File: rtl/router_cfg_regs.sv
// Module: configuration register file for the router.
// Holds one control word per four lines plus a global enable word.
// Writes are taken on the rising edge that samples reg_wr high; reads are combinational.
// Assumes REG_W is a whole multiple of the per-line byte and registers sit 4 bytes apart.
module router_cfg_regs #(
    parameter int N_OUT     = grp_router_pkg::DEF_N_OUT,
    parameter int ADDR_W    = grp_router_pkg::DEF_ADDR_W,
    parameter int REG_W     = grp_router_pkg::DEF_REG_W,
    parameter int LINE_BITS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr,
    input  logic [ADDR_W-1:0]                     reg_addr,
    input  logic [REG_W-1:0]                      reg_wdata,
    output logic [REG_W-1:0]                      reg_rdata,
    output logic [N_OUT-1:0][LINE_BITS-2:0]       cfg_line,
    output logic                                  glb_en
);
    localparam int PER_REG = REG_W / LINE_BITS;
    localparam int N_REG   = N_OUT / PER_REG;
    localparam int GLB_OFS = 4 * N_REG;
    localparam logic [LINE_BITS-1:0] LINE_MASK = {1'b0, {(LINE_BITS-1){1'b1}}};
    localparam logic [REG_W-1:0]     CTRL_MASK = {PER_REG{LINE_MASK}};

    logic [REG_W-1:0] ctrl_q [N_REG];

    // Load control words and the global enable on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_REG; r++) begin
                ctrl_q[r] <= '0;
            end
            glb_en <= 1'b0;
        end else if (reg_wr) begin
            for (int r = 0; r < N_REG; r++) begin
                if (reg_addr == ADDR_W'(4 * r)) begin
                    ctrl_q[r] <= reg_wdata & CTRL_MASK;
                end
            end
            if (reg_addr == ADDR_W'(GLB_OFS)) begin
                glb_en <= reg_wdata[0];
            end
        end
    end

    // Return the addressed register, or zero for an undefined offset.
    always_comb begin
        reg_rdata = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (reg_addr == ADDR_W'(4 * r)) begin
                reg_rdata = ctrl_q[r];
            end
        end
        if (reg_addr == ADDR_W'(GLB_OFS)) begin
            reg_rdata = {{(REG_W-1){1'b0}}, glb_en};
        end
    end

    // Slice each line's configuration out of its control word.
    for (genvar k = 0; k < N_OUT; k++) begin : g_slice
        assign cfg_line[k] = ctrl_q[k / PER_REG][(k % PER_REG) * LINE_BITS +: LINE_BITS-1];
    end

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(cfg_line) && $stable(glb_en))); // R8

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < ADDR_W'(GLB_OFS) && reg_addr[1:0] == 2'b00) |-> ((reg_rdata & ~CTRL_MASK) == '0)); // R2

    AST_GLB_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(GLB_OFS)) |-> (reg_rdata[REG_W-1:1] == '0)); // R3

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] != 2'b00 || reg_addr > ADDR_W'(GLB_OFS)) |-> (reg_rdata == '0)); // R9

endmodule

// File: rtl/router_line.sv
// Module: one routed output line.
// First level: the same line-select code picks one line from every source group.
// Second level: the group-select code picks one of those candidates.
// The result is gated by the line enable, the global enable and code validity.
// Assumes SRC_W == 2**SEL_W and N_GRP <= 2**SEL_W. The clock is used only by the assertions.
module router_line #(
    parameter int N_GRP = grp_router_pkg::DEF_N_GRP,
    parameter int SRC_W = grp_router_pkg::DEF_SRC_W,
    parameter int SEL_W = grp_router_pkg::DEF_SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_GRP*SRC_W-1:0]   src_in,
    input  logic [SEL_W-1:0]         l1_sel,
    input  logic [SEL_W-1:0]         l2_sel,
    input  logic                     line_en,
    input  logic                     glb_en,
    output logic                     route_o
);
    localparam int IDX_W = $clog2(N_GRP * SRC_W);

    logic [N_GRP-1:0] lvl1;
    logic             pick;
    logic             code_ok;

    // First level: one selector per group, all steered by the same code.
    for (genvar g = 0; g < N_GRP; g++) begin : g_lvl1
        logic [SRC_W-1:0] grp_bus;
        assign grp_bus  = src_in[g*SRC_W +: SRC_W];
        assign lvl1[g]  = grp_bus[l1_sel];
    end

    // Second level: choose a group result and flag whether the code names a real group.
    always_comb begin
        pick    = 1'b0;
        code_ok = 1'b0;
        for (int g = 0; g < N_GRP; g++) begin
            if (l2_sel == SEL_W'(g)) begin
                pick    = lvl1[g];
                code_ok = 1'b1;
            end
        end
    end

    // Output gate: only a valid, locally and globally enabled line passes.
    assign route_o = pick & code_ok & line_en & glb_en;

    // Flat source index, used only to cross-check the two-level path.
    logic [IDX_W-1:0] flat_idx;
    assign flat_idx = IDX_W'(l2_sel) * IDX_W'(SRC_W) + IDX_W'(l1_sel);

    AST_ROUTE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && glb_en && l2_sel < SEL_W'(N_GRP)) |-> (route_o == src_in[flat_idx])); // R4

    AST_RSV_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_sel >= SEL_W'(N_GRP)) |-> !route_o); // R5

    AST_LINE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |-> !route_o); // R6

    AST_GLB_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !route_o); // R7

endmodule

// File: rtl/grp_input_router.sv
// Module: top of the gated two-level input router.
// Combines the configuration register file with one routing line per output.
// Assumes the routing path is unregistered and configuration is written over the register bus.
module grp_input_router #(
    parameter int N_GRP  = grp_router_pkg::DEF_N_GRP,
    parameter int SRC_W  = grp_router_pkg::DEF_SRC_W,
    parameter int N_OUT  = grp_router_pkg::DEF_N_OUT,
    parameter int SEL_W  = grp_router_pkg::DEF_SEL_W,
    parameter int ADDR_W = grp_router_pkg::DEF_ADDR_W,
    parameter int REG_W  = grp_router_pkg::DEF_REG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic [N_GRP*SRC_W-1:0]   src_in,
    output logic [N_OUT-1:0]         route_out
);
    localparam int LINE_BITS = grp_router_pkg::line_bits(SEL_W);

    logic [N_OUT-1:0][LINE_BITS-2:0] cfg_line;
    logic                            glb_en;

    router_cfg_regs #(
        .N_OUT     (N_OUT),
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .LINE_BITS (LINE_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_line  (cfg_line),
        .glb_en    (glb_en)
    );

    // One routing line per output, each decoding its own configuration fields.
    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        router_line #(
            .N_GRP (N_GRP),
            .SRC_W (SRC_W),
            .SEL_W (SEL_W)
        ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_in  (src_in),
            .l1_sel  (cfg_line[k][SEL_W-1:0]),
            .l2_sel  (cfg_line[k][2*SEL_W-1:SEL_W]),
            .line_en (cfg_line[k][2*SEL_W]),
            .glb_en  (glb_en),
            .route_o (route_out[k])
        );
    end

endmodule

// File: tb/grp_input_router_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected values, a monitor pops and compares them.
module grp_input_router_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [39:0] src_in;
    logic [7:0]  route_out;

    always #2.5 clk = ~clk;

    grp_input_router u_grp_input_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_in    (src_in),
        .route_out (route_out)
    );

    typedef struct {
        logic [31:0] exp;
        bit          is_rd;
        string       req;
    } item_t;

    item_t       sb[$];
    event        chk_ev;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [31:0] sh_lo  = '0;
    logic [31:0] sh_hi  = '0;
    logic        sh_glb = 1'b0;

    // Reference model built from the requirements.
    function automatic logic [7:0] model_out(input logic [31:0] lo, input logic [31:0] hi,
                                             input logic glb, input logic [39:0] src);
        logic [7:0]  o = '0;
        logic [7:0]  b;
        logic [39:0] sh;
        for (int k = 0; k < 8; k++) begin
            b = (k < 4) ? lo[8*k +: 8] : hi[8*(k-4) +: 8];
            if (glb && b[6] && b[5:3] < 3'd5) begin
                sh   = src >> (int'(b[5:3]) * 8 + int'(b[2:0]));
                o[k] = sh[0];
            end
        end
        return o;
    endfunction

    task automatic push(input logic [31:0] exp, input bit is_rd, input string req);
        item_t it;
        it.exp = exp; it.is_rd = is_rd; it.req = req;
        sb.push_back(it);
        ->chk_ev;
        #0.3;
    endtask

    task automatic chk_out(input string req);
        #0.2;
        push({24'b0, model_out(sh_lo, sh_hi, sh_glb, src_in)}, 1'b0, req);
    endtask

    task automatic chk_rd(input logic [3:0] addr, input logic [31:0] exp, input string req);
        reg_addr = addr;
        #0.2;
        push(exp, 1'b1, req);
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        case (addr)
            4'h0: sh_lo  = data & 32'h7F7F7F7F;
            4'h4: sh_hi  = data & 32'h7F7F7F7F;
            4'h8: sh_glb = data[0];
            default: ;
        endcase
    endtask

    // Monitor: compares every queued expectation with the live ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_rd ? reg_rdata : {24'b0, route_out};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s %s actual=%h expected=%h", it.req,
                             it.is_rd ? "rdata" : "route_out", act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; src_in = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_out("R1");
        chk_rd(4'h0, 32'h0, "R1");
        chk_rd(4'h4, 32'h0, "R1");
        chk_rd(4'h8, 32'h0, "R1");

        // R2: field layout and spare bits; R3: global register width
        wr(4'h0, 32'hFFFFFFFF);
        chk_rd(4'h0, 32'h7F7F7F7F, "R2");
        wr(4'h4, 32'hA5C3F08E);
        chk_rd(4'h4, 32'h2543700E, "R2");
        wr(4'h8, 32'hFFFFFFFF);
        chk_rd(4'h8, 32'h00000001, "R3");
        chk_out("R2");

        // R9: undefined offsets ignored and read zero
        wr(4'hC, 32'h0);
        wr(4'h1, 32'h0);
        wr(4'h9, 32'h0);
        chk_rd(4'hC, 32'h0, "R9");
        chk_rd(4'h1, 32'h0, "R9");
        chk_rd(4'h0, 32'h7F7F7F7F, "R9");
        chk_rd(4'h4, 32'h2543700E, "R9");
        chk_rd(4'h8, 32'h00000001, "R9");
        chk_out("R9");

        // R4 / R5: every select pairing on every line
        for (int k = 0; k < 8; k++) begin
            wr(4'h0, 32'h0);
            wr(4'h4, 32'h0);
            for (int l2 = 0; l2 < 8; l2++) begin
                for (int l1 = 0; l1 < 8; l1++) begin
                    logic [7:0] b;
                    b = {2'b01, 3'(l2), 3'(l1)};
                    if (k < 4) wr(4'h0, {24'b0, b} << (8*k));
                    else       wr(4'h4, {24'b0, b} << (8*(k-4)));
                    if (l2 < 5) begin
                        src_in = 40'b1 << (l2*8 + l1);
                        chk_out("R4");
                        src_in = ~(40'b1 << (l2*8 + l1));
                        chk_out("R4");
                    end else begin
                        src_in = '1;
                        chk_out("R5");
                        src_in = 40'h5A5A5A5A5A;
                        chk_out("R5");
                    end
                end
            end
        end

        // R6: line enable cleared alone
        src_in = '1;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            b = {2'b00, 3'(k % 5), 3'(k)};
            wr(4'h0, 32'h0);
            wr(4'h4, 32'h0);
            if (k < 4) wr(4'h0, {24'b0, b} << (8*k));
            else       wr(4'h4, {24'b0, b} << (8*(k-4)));
            chk_out("R6");
            b[6] = 1'b1;
            if (k < 4) wr(4'h0, {24'b0, b} << (8*k));
            else       wr(4'h4, {24'b0, b} << (8*(k-4)));
            chk_out("R6");
        end

        // R7: global enable gates all lines
        wr(4'h0, 32'h4C4B4A49);
        wr(4'h4, 32'h63625A51);
        chk_out("R7");
        wr(4'h8, 32'h0);
        chk_out("R7");
        wr(4'h8, 32'h1);
        chk_out("R7");

        // R8: combinational source path, write lands on the sampling edge
        src_in = '0;
        chk_out("R8");
        src_in = '1;
        chk_out("R8");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0;
        chk_out("R8");
        @(posedge clk);
        sh_lo = 32'h0;
        chk_out("R8");
        @(negedge clk);
        reg_wr = 1'b0;
        chk_rd(4'h0, 32'h0, "R8");

        #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule